// File: doc/BRIEF.md
# Stereo Audio Serial Shift Engine

This block moves two's-complement audio samples across a two-channel serial audio link. On the transmit side it accepts one parallel sample per channel slot and shifts it onto the serial data line, most significant bit first. On the receive side it samples the serial input and rebuilds one parallel word per slot. All logic runs on the system clock. The serial bit clock arrives as two single-cycle strobes, one for its falling edge and one for its rising edge. The word-select level arrives with a pulse that marks the falling strobe on which that level changed.

Two framing conventions are supported. In the standard I2S framing the first data bit of a slot starts one bit period after word select changes. In the MSB-justified framing it starts in the same bit period. The sample width is either 8 or 16 bits. It need not match the number of bit periods in a slot: unused slot bits are sent as zeros, received bits past the sample width are dropped, and sample bits the slot did not carry are received as zeros. A polarity input chooses which word-select level means the right channel. Clock generation and sample storage lie outside the block. The block only offers a one-cycle request to the transmit buffer and a one-cycle delivery to the receive buffer.

Top module: `aud_ser_top`

## Requirements
- R1: Serial output is sent most significant bit first. Bit k of a slot, counting from 0 at the slot's first data bit period, carries sample bit (width-1-k). `sdo_o` changes only in the clock cycle after a `bclk_fall_i` strobe.
- R2: With `fmt_msbj_i`=0 (I2S framing), a slot's first data bit is driven on the first falling strobe after the falling strobe that carried `ws_edge_i`. `tx_ready_o` is high during that later strobe.
- R3: With `fmt_msbj_i`=1 (MSB-justified framing), a slot's first data bit is driven on the falling strobe that carries `ws_edge_i`. `tx_ready_o` is high during that same strobe.
- R4: When a slot has more bit periods than the sample width, every bit after the sample's LSB is sent as 0.
- R5: With `wide_i`=0 the sample is 8 bits wide and is taken from `tx_data_i[7:0]`, and `tx_data_i[15:8]` has no effect. With `wide_i`=1 all 16 bits of `tx_data_i` are used.
- R6: Serial input is captured on `bclk_rise_i` strobes. A finished slot is delivered with a one-cycle `rx_valid_o` pulse in the cycle after the rising strobe that carries the first data bit of the next slot. The first slot after reset produces no delivery.
- R7: The received word is left-aligned to the sample width. Input bits beyond the sample width are ignored, and missing low bits read as 0. With `wide_i`=0 the byte appears in `rx_data_o[7:0]` and `rx_data_o[15:8]` is 0.
- R8: The channel is right when (word-select level XOR `ws_pol_i`) is 1, and left otherwise. `chan_o` (0=left, 1=right) shows the channel of the slot being shifted from the cycle after its first falling strobe. `rx_chan_o` gives the channel of the word delivered with `rx_valid_o`.
- R9: When `tx_valid_i` is low while `tx_ready_o` is high, the slot is sent as all zeros and `underrun_o` pulses for one cycle in the following cycle.
- R10: While `rst` is high and in the first cycle after it, `sdo_o`, `tx_ready_o`, `rx_valid_o`, `underrun_o` and `chan_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_fall_i | input | 1 | One-cycle strobe marking a bit clock falling edge |
| bclk_rise_i | input | 1 | One-cycle strobe marking a bit clock rising edge |
| ws_i | input | 1 | Word-select level |
| ws_edge_i | input | 1 | High with the falling strobe on which ws_i changed |
| fmt_msbj_i | input | 1 | 0 = I2S framing, 1 = MSB-justified framing |
| wide_i | input | 1 | Sample width: 0 = 8 bits, 1 = 16 bits |
| ws_pol_i | input | 1 | Word-select polarity; right channel when ws_i XOR ws_pol_i is 1 |
| tx_valid_i | input | 1 | A transmit sample is present on tx_data_i |
| tx_data_i | input | 16 | Transmit sample, two's complement |
| tx_ready_o | output | 1 | Sample taken this cycle (start of a transmit slot) |
| sdo_o | output | 1 | Serial data out |
| underrun_o | output | 1 | One-cycle pulse: slot started without a sample |
| sdi_i | input | 1 | Serial data in |
| rx_valid_o | output | 1 | One-cycle pulse: rx_data_o holds a finished word |
| rx_data_o | output | 16 | Received word |
| rx_chan_o | output | 1 | Channel of the delivered word, 0 = left, 1 = right |
| chan_o | output | 1 | Channel of the slot in progress, 0 = left, 1 = right |

## Verification
The cycle that closes one slot is also the cycle that opens the next. A rising strobe that carries the first bit of a new slot must deliver the previous received word and restart capture with the new bit, all in one edge. The bench makes this happen at every slot boundary. It uses slot lengths above, equal to and below the sample width, and it checks that the delivered word keeps only the old slot's bits while the next delivery begins with the new bit. In the same way, a transmit slot start that finds no sample combines the underrun pulse with the zero load. This is judged from the zero serial bits and the pulse one cycle after the request.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

    typedef enum logic {
        FMT_I2S  = 1'b0,
        FMT_MSBJ = 1'b1
    } fmt_e;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    typedef struct packed {
        logic  tx_start;
        logic  rx_start;
        chan_e chan;
    } frame_ev_t;

    function automatic chan_e ws_to_chan(logic ws, logic pol);
        return chan_e'(ws ^ pol);
    endfunction

endpackage

// File: rtl/aud_ser_frame.sv
module aud_ser_frame
    import aud_ser_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bclk_fall,
    input  logic      bclk_rise,
    input  logic      ws,
    input  logic      ws_edge,
    input  logic      ws_pol,
    input  fmt_e      fmt,
    output frame_ev_t ev
);
    logic  edge_pend;
    logic  rx_arm;
    chan_e chan_q;
    logic  tx_start;

    assign tx_start    = bclk_fall & ((fmt == FMT_MSBJ) ? ws_edge : edge_pend);
    assign ev.tx_start = tx_start;
    assign ev.rx_start = bclk_rise & rx_arm;
    assign ev.chan     = chan_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_pend <= 1'b0;
            rx_arm    <= 1'b0;
            chan_q    <= CH_LEFT;
        end else begin
            if (bclk_fall)
                edge_pend <= ws_edge;
            if (tx_start) begin
                rx_arm <= 1'b1;
                chan_q <= ws_to_chan(ws, ws_pol);
            end else if (bclk_rise) begin
                rx_arm <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx #(
    parameter int SW = 16,
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bclk_fall,
    input  logic          start,
    input  logic          wide,
    input  logic          valid,
    input  logic [SW-1:0] data,
    output logic          sdo,
    output logic          underrun
);
    localparam int PAD = SW - NW;

    logic [SW-1:0] word;
    logic [SW-1:0] sh;

    always_comb begin
        if (!valid)
            word = '0;
        else if (wide)
            word = data;
        else
            word = {data[NW-1:0], {PAD{1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            sdo      <= 1'b0;
            underrun <= 1'b0;
        end else begin
            underrun <= start & ~valid;
            if (start) begin
                sdo <= word[SW-1];
                sh  <= {word[SW-2:0], 1'b0};
            end else if (bclk_fall) begin
                sdo <= sh[SW-1];
                sh  <= {sh[SW-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx
    import aud_ser_pkg::*;
#(
    parameter int SW = 16,
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bclk_rise,
    input  logic          start,
    input  logic          wide,
    input  logic          sdi,
    input  chan_e         chan,
    output logic          rx_valid,
    output logic [SW-1:0] rx_data,
    output chan_e         rx_chan
);
    localparam int CW  = $clog2(SW + 1);
    localparam int IW  = $clog2(SW);
    localparam int PAD = SW - NW;

    logic [SW-1:0] sh;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic [IW-1:0] idx;
    logic          have;
    chan_e         cur_chan;
    logic [SW-1:0] aligned;

    assign lim = wide ? CW'(SW) : CW'(NW);
    assign idx = IW'(SW - 1) - cnt[IW-1:0];
    assign aligned = wide ? sh : {{PAD{1'b0}}, sh[SW-1 -: NW]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            cnt      <= '0;
            have     <= 1'b0;
            cur_chan <= CH_LEFT;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_chan  <= CH_LEFT;
        end else begin
            rx_valid <= 1'b0;
            if (start) begin
                if (have) begin
                    rx_valid <= 1'b1;
                    rx_data  <= aligned;
                    rx_chan  <= cur_chan;
                end
                sh       <= {sdi, {(SW-1){1'b0}}};
                cnt      <= CW'(1);
                have     <= 1'b1;
                cur_chan <= chan;
            end else if (bclk_rise && have && (cnt < lim)) begin
                sh[idx] <= sdi;
                cnt     <= cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/aud_ser_top.sv
module aud_ser_top
    import aud_ser_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int NARROW_W = 8
) (
    input  logic                bclk_fall_i,
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk_rise_i,
    input  logic                ws_i,
    input  logic                ws_edge_i,
    input  logic                fmt_msbj_i,
    input  logic                wide_i,
    input  logic                ws_pol_i,
    input  logic                tx_valid_i,
    input  logic [SAMPLE_W-1:0] tx_data_i,
    output logic                tx_ready_o,
    output logic                sdo_o,
    output logic                underrun_o,
    input  logic                sdi_i,
    output logic                rx_valid_o,
    output logic [SAMPLE_W-1:0] rx_data_o,
    output logic                rx_chan_o,
    output logic                chan_o
);
    frame_ev_t ev;
    chan_e     rx_chan;

    aud_ser_frame frame_i (
        .clk       (clk),
        .rst       (rst),
        .bclk_fall (bclk_fall_i),
        .bclk_rise (bclk_rise_i),
        .ws        (ws_i),
        .ws_edge   (ws_edge_i),
        .ws_pol    (ws_pol_i),
        .fmt       (fmt_e'(fmt_msbj_i)),
        .ev        (ev)
    );

    aud_ser_tx #(.SW(SAMPLE_W), .NW(NARROW_W)) tx_i (
        .clk       (clk),
        .rst       (rst),
        .bclk_fall (bclk_fall_i),
        .start     (ev.tx_start),
        .wide      (wide_i),
        .valid     (tx_valid_i),
        .data      (tx_data_i),
        .sdo       (sdo_o),
        .underrun  (underrun_o)
    );

    aud_ser_rx #(.SW(SAMPLE_W), .NW(NARROW_W)) rx_i (
        .clk       (clk),
        .rst       (rst),
        .bclk_rise (bclk_rise_i),
        .start     (ev.rx_start),
        .wide      (wide_i),
        .sdi       (sdi_i),
        .chan      (ev.chan),
        .rx_valid  (rx_valid_o),
        .rx_data   (rx_data_o),
        .rx_chan   (rx_chan)
    );

    assign tx_ready_o = ev.tx_start;
    assign chan_o     = ev.chan;
    assign rx_chan_o  = rx_chan;
endmodule

// File: rtl/aud_ser_chk.sv
module aud_ser_chk #(
    parameter int SW = 16,
    parameter int NW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          bclk_fall_i,
    input logic          bclk_rise_i,
    input logic          ws_edge_i,
    input logic          fmt_msbj_i,
    input logic          wide_i,
    input logic          tx_valid_i,
    input logic          tx_ready_o,
    input logic          sdo_o,
    input logic          underrun_o,
    input logic          rx_valid_o,
    input logic [SW-1:0] rx_data_o,
    input logic          chan_o
);
    // R1: serial output moves only after a falling strobe
    a_r1_sdo_after_fall: assert property (@(posedge clk) disable iff (rst)
        !$past(bclk_fall_i) |-> $stable(sdo_o));

    // R2: a transmit slot opens only on a falling strobe
    a_r2_ready_on_fall: assert property (@(posedge clk) disable iff (rst)
        tx_ready_o |-> bclk_fall_i);

    // R3: in MSB-justified framing the slot opens with the word-select edge
    a_r3_msbj_ready_at_edge: assert property (@(posedge clk) disable iff (rst)
        (tx_ready_o && fmt_msbj_i) |-> ws_edge_i);

    // R6: deliveries follow a rising strobe
    a_r6_rx_after_rise: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> $past(bclk_rise_i));

    // R7: narrow words have a zero upper part
    a_r7_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (rx_valid_o && !$past(wide_i)) |-> (rx_data_o[SW-1:NW] == '0));

    // R8: channel indication moves only at a slot start
    a_r8_chan_at_start: assert property (@(posedge clk) disable iff (rst)
        !$past(tx_ready_o) |-> $stable(chan_o));

    // R9: underrun comes from a request without a sample
    a_r9_underrun_cause: assert property (@(posedge clk) disable iff (rst)
        underrun_o |-> $past(tx_ready_o && !tx_valid_i));

    // R9: the first bit of an underrun slot is zero
    a_r9_underrun_zero: assert property (@(posedge clk) disable iff (rst)
        underrun_o |-> !sdo_o);
endmodule

bind aud_ser_top aud_ser_chk #(.SW(SAMPLE_W), .NW(NARROW_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .bclk_fall_i (bclk_fall_i),
    .bclk_rise_i (bclk_rise_i),
    .ws_edge_i   (ws_edge_i),
    .fmt_msbj_i  (fmt_msbj_i),
    .wide_i      (wide_i),
    .tx_valid_i  (tx_valid_i),
    .tx_ready_o  (tx_ready_o),
    .sdo_o       (sdo_o),
    .underrun_o  (underrun_o),
    .rx_valid_o  (rx_valid_o),
    .rx_data_o   (rx_data_o),
    .chan_o      (chan_o)
);

// File: tb/aud_ser_top_tb_top.sv
module aud_ser_top_tb_top;
    localparam int SW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          bclk_fall = 1'b0, bclk_rise = 1'b0, ws = 1'b0, ws_edge = 1'b0;
    logic          fmt_msbj = 1'b0, wide = 1'b0, ws_pol = 1'b0;
    logic          tx_valid = 1'b0, sdi = 1'b0;
    logic [SW-1:0] tx_data = '0;
    logic          tx_ready, sdo, underrun, rx_valid, rx_chan, chan;
    logic [SW-1:0] rx_data;

    aud_ser_top dut_i (
        .bclk_fall_i (bclk_fall),
        .clk         (clk),
        .rst         (rst),
        .bclk_rise_i (bclk_rise),
        .ws_i        (ws),
        .ws_edge_i   (ws_edge),
        .fmt_msbj_i  (fmt_msbj),
        .wide_i      (wide),
        .ws_pol_i    (ws_pol),
        .tx_valid_i  (tx_valid),
        .tx_data_i   (tx_data),
        .tx_ready_o  (tx_ready),
        .sdo_o       (sdo),
        .underrun_o  (underrun),
        .sdi_i       (sdi),
        .rx_valid_o  (rx_valid),
        .rx_data_o   (rx_data),
        .rx_chan_o   (rx_chan),
        .chan_o      (chan)
    );

    int checks = 0;
    int fails  = 0;
    logic cur_ws = 1'b0;
    logic pend_rx = 1'b0;
    logic [SW-1:0] exp_rx = '0;
    logic exp_rxch = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_tx_bit(logic [SW-1:0] d, logic wd, logic vld, int b);
        int w = wd ? 16 : 8;
        if (!vld || b >= w) return 1'b0;
        return wd ? d[15-b] : d[7-b];
    endfunction

    function automatic logic [SW-1:0] exp_rx_word(logic [31:0] bits, int nb, logic wd);
        logic [SW-1:0] r = '0;
        int w = wd ? 16 : 8;
        for (int i = 0; i < w; i++)
            if (i < nb) r[w-1-i] = bits[i];
        return r;
    endfunction

    task automatic bit_period(input logic ws_val, input logic edg, input logic sbit,
                              output logic rdy, output logic so, output logic und,
                              output logic ch, output logic rv, output logic [SW-1:0] rd,
                              output logic rc);
        @(negedge clk);
        bclk_fall = 1'b1; ws = ws_val; ws_edge = edg;
        #1 rdy = tx_ready;
        @(negedge clk);
        bclk_fall = 1'b0; ws_edge = 1'b0;
        so = sdo; und = underrun; ch = chan;
        @(negedge clk);
        bclk_rise = 1'b1; sdi = sbit;
        @(negedge clk);
        bclk_rise = 1'b0;
        rv = rx_valid; rd = rx_data; rc = rx_chan;
    endtask

    task automatic run_slot(input logic lvl, input logic nxt, input int nbits, input logic vld,
                            input logic [SW-1:0] d, input logic [31:0] rbits, input bit check);
        logic rdy, so, und, ch, rv, rc, wsv, edg;
        logic [SW-1:0] rd;
        string req;
        int w = wide ? 16 : 8;
        tx_valid = vld; tx_data = d;
        for (int b = 0; b < nbits; b++) begin
            wsv = (!fmt_msbj && b == nbits - 1) ? nxt : lvl;
            edg = (wsv != cur_ws);
            cur_ws = wsv;
            bit_period(wsv, edg, rbits[b], rdy, so, und, ch, rv, rd, rc);
            if (b == 0) begin
                tx_valid = 1'b0;
                if (pend_rx) begin
                    chk(rv == 1'b1, "R6 delivery pulse", 32'(rv), 1);
                    chk(rd == exp_rx, "R7 received word", 32'(rd), 32'(exp_rx));
                    chk(rc == exp_rxch, "R8 rx channel", 32'(rc), 32'(exp_rxch));
                    pend_rx = 1'b0;
                end
            end else if (check) begin
                chk(rv == 1'b0, "R6 no delivery mid-slot", 32'(rv), 0);
            end
            if (check) begin
                if (b == 0) begin
                    chk(rdy == 1'b1, fmt_msbj ? "R3 ready at edge" : "R2 ready after edge", 32'(rdy), 1);
                    chk(und == !vld, "R9 underrun pulse", 32'(und), 32'(!vld));
                    chk(ch == (lvl ^ ws_pol), "R8 channel", 32'(ch), 32'(lvl ^ ws_pol));
                end else begin
                    chk(rdy == 1'b0, "R2 no request mid-slot", 32'(rdy), 0);
                end
                if (!vld)         req = "R9 zero slot";
                else if (b >= w)  req = "R4 zero fill";
                else if (!wide)   req = "R5 narrow bit";
                else              req = "R1 wide bit";
                chk(so == exp_tx_bit(d, wide, vld, b), req, 32'(so), 32'(exp_tx_bit(d, wide, vld, b)));
            end
        end
        if (check) begin
            pend_rx  = 1'b1;
            exp_rx   = exp_rx_word(rbits, nbits, wide);
            exp_rxch = lvl ^ ws_pol;
        end
    endtask

    task automatic run_seq(input logic fm, input logic wd, input logic pl, input int nslots);
        int nb;
        int w = wd ? 16 : 8;
        rst = 1'b1; bclk_fall = 0; bclk_rise = 0; ws = 0; ws_edge = 0; tx_valid = 0;
        fmt_msbj = fm; wide = wd; ws_pol = pl; cur_ws = 1'b0; pend_rx = 1'b0;
        repeat (3) @(negedge clk);
        chk({sdo, tx_ready, rx_valid, underrun, chan} == 5'b0, "R10 in reset",
            32'({sdo, tx_ready, rx_valid, underrun, chan}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk({sdo, tx_ready, rx_valid, underrun, chan} == 5'b0, "R10 after reset",
            32'({sdo, tx_ready, rx_valid, underrun, chan}), 0);
        run_slot(1'b0, 1'b1, 3, 1'b0, '0, '0, 0);
        for (int i = 1; i <= nslots; i++) begin
            case (i)
                1: nb = w;
                2: nb = w + 3;
                3: nb = w - 2;
                4: nb = 3;
                default: nb = 3 + int'($urandom_range(21));
            endcase
            run_slot(logic'(i % 2), logic'((i + 1) % 2), nb,
                     (i == 3) ? 1'b0 : ($urandom_range(9) != 0),
                     SW'($urandom), $urandom, 1);
        end
        run_slot(logic'((nslots + 1) % 2), logic'((nslots + 1) % 2), 2, 1'b0, '0, '0, 0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int cfg = 0; cfg < 8; cfg++)
            run_seq(logic'(cfg[0]), logic'(cfg[1]), logic'(cfg[2]), 10);
        summary();
        $finish;
    end
endmodule